// File: doc/BRIEF.md
# Duplicate Tag RAM Power-Up Test and Initialiser

This sequencer runs once after reset, before any snoop lookup may use the duplicate tag RAM. It makes two full passes over the array. Each pass writes every entry and then reads every entry back. On the read-back it compares each word with the value written and checks the word's parity. The first pass writes an address-dependent pattern in which every entry is marked valid. The second pass writes the bitwise inverse of that pattern. As a result, every stored bit is exercised both as a 1 and as a 0, and the array is left with every entry invalid and with even parity.

The tag RAM sits outside the block. It captures address, write data and write enable on the clock edge. A read issued with the output enable high returns its data in the next cycle. Snoop requests presented to the block are passed on only once the sequence has finished. The first failing address is recorded. The sequence always runs to the end, even after a failure, so the array is always initialised.

Top module: `tag_ram_init`

## Requirements
- R1: From the first cycle after reset, the block writes addresses 0 to DEPTH-1 in ascending order, one per cycle, with `ramWe` high. The word written at address a is {parity, valid=1, tag}. In that word, tag = a XOR SEED (TAG_W bits), the valid bit sits at position TAG_W, and the parity bit sits in the MSB and is chosen so that the XOR of all bits of the word is 0.
- R2: Directly after the first write pass, the block reads addresses 0 to DEPTH-1 in ascending order, one per cycle, with `ramOe` high and `ramWe` low.
- R3: The block then writes every address again in ascending order with the bitwise inverse of the R1 word. This word has valid=0, and its parity is still even because TAG_W is even.
- R4: The block then reads every address again in ascending order.
- R5: The block compares each read word, taken one cycle after its read cycle, against the word written by that pass. It also checks the word for odd parity. Any mismatch raises `initFail` two cycles after the read cycle, and `initFail` stays high until reset.
- R6: `failAddr` is 0 until the first failure. From then on it holds the address of the first failing read, and later failures do not change it.
- R7: A failure does not shorten the run. Every healthy entry ends holding the inverted word: valid bit 0 and even parity.
- R8: `initDone` rises 4*DEPTH+1 cycles after reset is released (one idle cycle follows the last read) and then stays high. `initDonePulse` is high for that first cycle only.
- R9: `initPass` is high exactly when `initDone` is high and `initFail` is low.
- R10: `snoopGrant` follows `snoopReqIn` only while `initDone` is high, and is low before that.
- R11: `ramWe` and `ramOe` are never high in the same cycle. Both are low, and `ramAddr` and `ramWrData` are 0, once the passes have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ramAddr | output | ADDR_W | Tag RAM address |
| ramWrData | output | TAG_W+2 | Tag RAM write data |
| ramWe | output | 1 | Tag RAM write enable |
| ramOe | output | 1 | Tag RAM read/output enable |
| ramRdData | input | TAG_W+2 | Tag RAM read data, valid one cycle after ramOe |
| snoopReqIn | input | 1 | Incoming snoop lookup request |
| snoopGrant | output | 1 | Snoop request passed on after initialisation |
| initDone | output | 1 | Sequence complete (level) |
| initDonePulse | output | 1 | One-cycle strobe when the sequence completes |
| initPass | output | 1 | Completed with no failure |
| initFail | output | 1 | Sticky failure flag |
| failAddr | output | ADDR_W | Address of the first failing read |

## Verification
On every cycle, the assertions check that write and read enables are exclusive, that completion is sticky with a single strobe, that the failure flag and first-failure address do not move once set, and that snoop grants and the pass flag appear only after completion. Only the bench's scenarios can show that the address order, the write data of both passes, the fail timing relative to a faulty read, and the choice of the first failing address among several injected stuck bits are right. The same applies to the final array contents, which the bench checks from its own RAM model.

// File: rtl/tag_init_pkg.sv
package tag_init_pkg;

  typedef enum logic [2:0] {
    PH_WR1,
    PH_RD1,
    PH_WR2,
    PH_RD2,
    PH_DRAIN,
    PH_DONE
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wr;
    logic rd;
    logic inv;
  } strobe_t;

endpackage

// File: rtl/tag_init_ctrl.sv
module tag_init_ctrl
  import tag_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              donePulse
);

  phase_e            phase;
  logic [ADDR_W-1:0] cnt;
  logic              doneD;
  logic              lastAddr;

  assign lastAddr = &cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_WR1;
      cnt   <= '0;
      doneD <= 1'b0;
    end else begin
      doneD <= done;
      case (phase)
        PH_WR1, PH_RD1, PH_WR2, PH_RD2: begin
          cnt <= cnt + 1'b1;
          if (lastAddr) begin
            case (phase)
              PH_WR1:  phase <= PH_RD1;
              PH_RD1:  phase <= PH_WR2;
              PH_WR2:  phase <= PH_RD2;
              default: phase <= PH_DRAIN;
            endcase
          end
        end
        PH_DRAIN: phase <= PH_DONE;
        default:  phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    stb.wr  = (phase == PH_WR1) || (phase == PH_WR2);
    stb.rd  = (phase == PH_RD1) || (phase == PH_RD2);
    stb.inv = (phase == PH_WR2) || (phase == PH_RD2);
  end

  assign addr      = cnt;
  assign done      = (phase == PH_DONE);
  assign donePulse = done & ~doneD;

endmodule

// File: rtl/tag_init_dp.sv
module tag_init_dp
  import tag_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned SEED   = 43,
  localparam int unsigned DW    = TAG_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DW-1:0]     ramWrData,
  output logic              ramWe,
  output logic              ramOe,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  // {parity, valid, tag}, even parity over the whole word
  function automatic logic [DW-1:0] patternWord(input logic [ADDR_W-1:0] a,
                                                input logic inv);
    logic [TAG_W-1:0] tag;
    logic [DW-1:0]    w;
    tag = TAG_W'(a) ^ TAG_W'(SEED);
    w   = {^{1'b1, tag}, 1'b1, tag};
    return inv ? ~w : w;
  endfunction

  logic              chkValid;
  logic              chkInv;
  logic [ADDR_W-1:0] chkAddr;
  logic              mismatch;
  logic              parityErr;
  logic              bad;

  assign ramWe     = stb.wr;
  assign ramOe     = stb.rd;
  assign ramAddr   = (stb.wr || stb.rd) ? addr : '0;
  assign ramWrData = stb.wr ? patternWord(addr, stb.inv) : '0;

  assign mismatch  = ramRdData != patternWord(chkAddr, chkInv);
  assign parityErr = ^ramRdData;
  assign bad       = chkValid && (mismatch || parityErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkValid <= 1'b0;
      chkInv   <= 1'b0;
      chkAddr  <= '0;
      fail     <= 1'b0;
      failAddr <= '0;
    end else begin
      chkValid <= stb.rd;
      chkInv   <= stb.inv;
      chkAddr  <= addr;
      if (bad && !fail) begin
        fail     <= 1'b1;
        failAddr <= chkAddr;
      end
    end
  end

endmodule

// File: rtl/tag_ram_init.sv
module tag_ram_init
  import tag_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned SEED   = 43
) (
  input  logic                clk,
  input  logic                rstN,
  output logic [ADDR_W-1:0]   ramAddr,
  output logic [TAG_W+1:0]    ramWrData,
  output logic                ramWe,
  output logic                ramOe,
  input  logic [TAG_W+1:0]    ramRdData,
  input  logic                snoopReqIn,
  output logic                snoopGrant,
  output logic                initDone,
  output logic                initDonePulse,
  output logic                initPass,
  output logic                initFail,
  output logic [ADDR_W-1:0]   failAddr
);

  strobe_t           stb;
  logic [ADDR_W-1:0] seqAddr;

  tag_init_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (seqAddr),
    .done      (initDone),
    .donePulse (initDonePulse)
  );

  tag_init_dp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SEED(SEED)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addr      (seqAddr),
    .ramRdData (ramRdData),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .ramWe     (ramWe),
    .ramOe     (ramOe),
    .fail      (initFail),
    .failAddr  (failAddr)
  );

  assign initPass   = initDone & ~initFail;
  assign snoopGrant = snoopReqIn & initDone;

endmodule

// File: rtl/tag_ram_init_chk.sv
module tag_ram_init_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TAG_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [TAG_W+1:0]  ramWrData,
  input logic              ramWe,
  input logic              ramOe,
  input logic [TAG_W+1:0]  ramRdData,
  input logic              snoopReqIn,
  input logic              snoopGrant,
  input logic              initDone,
  input logic              initDonePulse,
  input logic              initPass,
  input logic              initFail,
  input logic [ADDR_W-1:0] failAddr
);

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(ramWe && ramOe)); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) initDone |-> (!ramWe && !ramOe && ramAddr == '0)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN) initDone |=> initDone); // R8
  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rstN) initDonePulse |=> !initDonePulse); // R8
  AST_PULSE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN) initDonePulse |-> initDone); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN) initFail |=> initFail); // R5
  AST_FAIL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN) initFail |=> $stable(failAddr)); // R6
  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rstN) snoopGrant |-> (initDone && snoopReqIn)); // R10
  AST_PASS_QUAL: assert property (@(posedge clk) disable iff (!rstN) initPass |-> (initDone && !initFail)); // R9

endmodule

bind tag_ram_init tag_ram_init_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tag_ram_init_bench.sv
module tag_ram_init_bench;

  localparam int AW    = 4;
  localparam int TW    = 6;
  localparam int SEEDV = 43;
  localparam int DW    = TW + 2;
  localparam int D     = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWrData;
  logic          ramWe, ramOe;
  logic [DW-1:0] ramRdData;
  logic          snoopReqIn = 1'b0;
  logic          snoopGrant, initDone, initDonePulse, initPass, initFail;
  logic [AW-1:0] failAddr;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // stuck-bit faults applied on RAM read
  logic          fEn   [2];
  logic [AW-1:0] fAddr [2];
  int            fBit  [2];
  logic          fVal  [2];

  logic [DW-1:0] mem [D];

  always #2.5 clk = ~clk;

  tag_ram_init #(.ADDR_W(AW), .TAG_W(TW), .SEED(SEEDV)) u_tag_ram_init (
    .clk(clk), .rstN(rstN), .ramAddr(ramAddr), .ramWrData(ramWrData),
    .ramWe(ramWe), .ramOe(ramOe), .ramRdData(ramRdData),
    .snoopReqIn(snoopReqIn), .snoopGrant(snoopGrant), .initDone(initDone),
    .initDonePulse(initDonePulse), .initPass(initPass), .initFail(initFail),
    .failAddr(failAddr)
  );

  function automatic logic [DW-1:0] pat(input int a, input logic inv);
    logic [TW-1:0] t;
    logic [DW-1:0] w;
    t = TW'(a) ^ TW'(SEEDV);
    w = {^{1'b1, t}, 1'b1, t};
    return inv ? ~w : w;
  endfunction

  function automatic logic [DW-1:0] faulty(input int a, input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    for (int i = 0; i < 2; i++)
      if (fEn[i] && int'(fAddr[i]) == a) r[fBit[i]] = fVal[i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWrData;
    if (ramOe) ramRdData <= faulty(int'(ramAddr), mem[ramAddr]);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      miscompares++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic doRun(input string name);
    int  badCycle = -1;
    int  badAddr  = 0;
    rstN = 1'b0;
    for (int i = 0; i < D; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(initDone == 1'b0, "R8 reset done", initDone, 0);
    chk(initFail == 1'b0, "R5 reset fail", initFail, 0);
    chk(snoopGrant == 1'b0, "R10 reset grant", snoopGrant, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 4 * D + 8; k++) begin
      logic          eWe, eOe, eInv, eDone, ePulse, eFail;
      int            a;
      logic [DW-1:0] eWd;
      logic [AW-1:0] eAddr;
      snoopReqIn = (k % 3) != 0;
      #1;
      eWe = (k < D) || (k >= 2 * D && k < 3 * D);
      eOe = (k >= D && k < 2 * D) || (k >= 3 * D && k < 4 * D);
      eInv = k >= 2 * D;
      a = k % D;
      eAddr = (eWe || eOe) ? AW'(a) : '0;
      eWd = eWe ? pat(a, eInv) : '0;
      if (eOe && badCycle < 0 && faulty(a, pat(a, eInv)) != pat(a, eInv)) begin
        badCycle = k + 2;
        badAddr  = a;
      end
      eDone  = k >= 4 * D + 1;
      ePulse = k == 4 * D + 1;
      eFail  = badCycle >= 0 && k >= badCycle;
      chk(ramWe == eWe, eInv ? "R3 we" : "R1 we", ramWe, eWe);
      chk(ramOe == eOe, eInv ? "R4 oe" : "R2 oe", ramOe, eOe);
      chk(ramAddr == eAddr, eInv ? "R4 addr" : "R2 addr", ramAddr, eAddr);
      chk(ramWrData == eWd, eInv ? "R3 wdata" : "R1 wdata", ramWrData, eWd);
      chk(initDone == eDone, "R8 done", initDone, eDone);
      chk(initDonePulse == ePulse, "R8 pulse", initDonePulse, ePulse);
      chk(initFail == eFail, "R5 fail", initFail, eFail);
      chk(failAddr == (eFail ? AW'(badAddr) : AW'(0)), "R6 failAddr", failAddr,
          eFail ? badAddr : 0);
      chk(initPass == (eDone && !eFail), "R9 pass", initPass, eDone && !eFail);
      chk(snoopGrant == (snoopReqIn && eDone), "R10 grant", snoopGrant, snoopReqIn && eDone);
      chk(!(ramWe && ramOe), "R11 exclusive", {ramWe, ramOe}, 0);
      @(negedge clk);
    end
    // final contents for healthy entries: R7
    for (int i = 0; i < D; i++) begin
      logic hit = 1'b0;
      for (int f = 0; f < 2; f++) if (fEn[f] && int'(fAddr[f]) == i) hit = 1'b1;
      if (!hit) begin
        chk(mem[i] == pat(i, 1'b1), "R7 final word", mem[i], pat(i, 1'b1));
        chk(mem[i][TW] == 1'b0 && (^mem[i]) == 1'b0, "R7 invalid+parity", mem[i], pat(i, 1'b1));
      end
    end
    $display("run %s finished", name);
  endtask

  initial begin
    logic [DW-1:0] e;
    fEn[0] = 1'b0; fEn[1] = 1'b0;
    fAddr[0] = '0; fAddr[1] = '0; fBit[0] = 0; fBit[1] = 0; fVal[0] = 1'b0; fVal[1] = 1'b0;
    doRun("clean");

    // one fault visible in the first read pass: R5, R7
    e = pat(5, 1'b0);
    fEn[0] = 1'b1; fAddr[0] = 4'd5; fBit[0] = 3; fVal[0] = ~e[3];
    doRun("single");

    // fault at 11 seen in pass one, fault at 2 seen only in pass two: R6
    e = pat(11, 1'b0);
    fAddr[0] = 4'd11; fBit[0] = 6; fVal[0] = ~e[6];
    e = pat(2, 1'b0);
    fEn[1] = 1'b1; fAddr[1] = 4'd2; fBit[1] = 7; fVal[1] = e[7];
    doRun("double");

    // only the pass-two fault: R3, R4 read-back as 0 path
    fEn[0] = 1'b0;
    doRun("second-pass");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule